// File: doc/BRIEF.md
# Debug Signal Observation Multiplexer

This block drives a small set of debug output pins from a much larger pool of internal probe signals. Each pin owns a fixed group of probe inputs and a selector field in a shared mux register. The selector names the probe in that group that reaches the pin. The highest selector code is reserved: it routes a bit of a software-owned general-purpose output (GPO) register to the pin instead of a probe. Software can therefore watch hardware activity on some pins and toggle marker bits on others at the same time.

Software programs the block through a zero-wait-state APB-style register port. A global enable gates every pin to 0 while it is clear. The GPO register is never written directly. Bits are raised through a set register and dropped through a clear register, so one agent can change its own marker bits without a read-modify-write. The set register reads back the whole GPO state, and writing that value to it again restores the state after a power-down. A read-only register shows the levels currently on the pins. Version and identification words are fixed at elaboration.

Top module: `dbg_obs_mux`

## Requirements
- R1: After reset, the enable, the mux register and the GPO register are 0, and every pin drives 0.
- R2: Bit 0 of the control register at offset 0x000 is the enable. While it is 0, every pin drives 0 whatever the mux and GPO settings. The control register reads back bit 0, and all its other bits read 0.
- R3: For pin n, mux register (offset 0x004) bits [4n+3:4n] hold selector s. For s in 0..14 with the enable at 1, the pin shows probe input bit n*16+s.
- R4: Selector code 15 on pin n makes the pin show GPO bit n, and that pin's probe inputs have no effect.
- R5: A write to the set register (offset 0x014) sets each GPO bit written as 1. Bits written as 0 keep their value.
- R6: A write to the clear register (offset 0x018) clears each GPO bit written as 1. Bits written as 0 keep their value.
- R7: Reads of the set register and of the GPO value register (offset 0x01C) return the GPO state in bits [7:0]. Writing a saved set-register value back to the set register after a full clear restores that state.
- R8: The pin value register (offset 0x010) returns the 8 levels now on the pins in bits [7:0].
- R9: The version register (offset 0x3F4) reads the major version in bits [7:4] and the minor version in bits [3:0]. The identification registers at 0x3F8 and 0x3FC read fixed words.
- R10: Writes to the read-only registers (0x010, 0x01C, 0x3F4, 0x3F8, 0x3FC) and to unmapped offsets change no state. Unmapped offsets and the clear register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Access phase of a transfer |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 12 | Byte offset of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while psel is high and pwrite is low |
| probe_in | input | 128 | Probe inputs; pin n owns bits [16n+15:16n] |
| dbg_out | output | 8 | Debug output pins |

## Verification
Two functions can meet in one cycle: a GPO update arriving through a set or clear write, and the probe-to-pin path of the same pin. The bench forces this by putting code 15 on a pin and then issuing set and clear writes while it changes that pin's probe group on every transfer. The pin must track the GPO bit from the cycle after the write and ignore the probes. A second coincidence pairs a read of the pin value register with probe edges on code 0..14 pins. The bench compares that read against pin levels it computes from its own copy of the mux, GPO and probe state.

// File: rtl/dbg_obs_mux_pkg.sv
package dbg_obs_mux_pkg;
   localparam int ADDR_W = 12;
   localparam int DATA_W = 32;

   localparam logic [ADDR_W-1:0] OFS_CTRL    = 12'h000;
   localparam logic [ADDR_W-1:0] OFS_SELECT  = 12'h004;
   localparam logic [ADDR_W-1:0] OFS_PINVAL  = 12'h010;
   localparam logic [ADDR_W-1:0] OFS_GPO_SET = 12'h014;
   localparam logic [ADDR_W-1:0] OFS_GPO_CLR = 12'h018;
   localparam logic [ADDR_W-1:0] OFS_GPO_VAL = 12'h01C;
   localparam logic [ADDR_W-1:0] OFS_VERSION = 12'h3F4;
   localparam logic [ADDR_W-1:0] OFS_ID0     = 12'h3F8;
   localparam logic [ADDR_W-1:0] OFS_ID1     = 12'h3FC;
endpackage

// File: rtl/dbg_obs_mux_regs.sv
module dbg_obs_mux_regs
   import dbg_obs_mux_pkg::*;
#(
   parameter int          NUM_PINS  = 8,
   parameter int          SEL_W     = 4,
   parameter logic [3:0]  VER_MAJOR = 4'd1,
   parameter logic [3:0]  VER_MINOR = 4'd0,
   parameter logic [31:0] ID_WORD0  = 32'h4442_4D58,
   parameter logic [31:0] ID_WORD1  = 32'h0000_A3C5
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      psel,
   input  logic                      penable,
   input  logic                      pwrite,
   input  logic [ADDR_W-1:0]         paddr,
   input  logic [DATA_W-1:0]         pwdata,
   output logic [DATA_W-1:0]         prdata,
   input  logic [NUM_PINS-1:0]       pin_val,
   output logic                      en,
   output logic [NUM_PINS*SEL_W-1:0] sel_all,
   output logic [NUM_PINS-1:0]       gpo
);
   localparam int SEL_TOT = NUM_PINS * SEL_W;

   initial begin
      if (SEL_TOT > DATA_W) $error("selector fields exceed the data width");
      if (NUM_PINS > DATA_W) $error("pin count exceeds the data width");
   end

   logic                wr;
   logic [NUM_PINS-1:0] set_mask, clr_mask;

   assign wr       = psel && penable && pwrite;
   assign set_mask = (wr && paddr == OFS_GPO_SET) ? pwdata[NUM_PINS-1:0] : '0;
   assign clr_mask = (wr && paddr == OFS_GPO_CLR) ? pwdata[NUM_PINS-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en      <= 1'b0;
         sel_all <= '0;
         gpo     <= '0;
      end else begin
         if (wr && paddr == OFS_CTRL)   en      <= pwdata[0];
         if (wr && paddr == OFS_SELECT) sel_all <= pwdata[SEL_TOT-1:0];
         gpo <= (gpo | set_mask) & ~clr_mask;
      end
   end

   always_comb begin
      prdata = '0;
      case (paddr)
         OFS_CTRL:    prdata[0] = en;
         OFS_SELECT:  prdata[SEL_TOT-1:0] = sel_all;
         OFS_PINVAL:  prdata[NUM_PINS-1:0] = pin_val;
         OFS_GPO_SET: prdata[NUM_PINS-1:0] = gpo;
         OFS_GPO_VAL: prdata[NUM_PINS-1:0] = gpo;
         OFS_VERSION: prdata[7:0] = {VER_MAJOR, VER_MINOR};
         OFS_ID0:     prdata = ID_WORD0;
         OFS_ID1:     prdata = ID_WORD1;
         default:     prdata = '0;
      endcase
   end

   p_set_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && paddr == OFS_GPO_SET) |=>
      ((gpo & $past(pwdata[NUM_PINS-1:0])) == $past(pwdata[NUM_PINS-1:0])));

   p_clr_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && paddr == OFS_GPO_CLR) |=> ((gpo & $past(pwdata[NUM_PINS-1:0])) == '0));

   p_gpo_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && (paddr == OFS_GPO_SET || paddr == OFS_GPO_CLR)) |=> $stable(gpo));

   p_ctrl_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && (paddr == OFS_CTRL || paddr == OFS_SELECT)) |=> ($stable(en) && $stable(sel_all)));
endmodule

// File: rtl/dbg_obs_mux_pin.sv
module dbg_obs_mux_pin #(
   parameter int SRC_N   = 16,
   parameter int SEL_W   = 4,
   parameter bit REG_OUT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [SEL_W-1:0] sel,
   input  logic             gpo_bit,
   input  logic [SRC_N-1:0] probes,
   output logic             pin
);
   localparam logic [SEL_W-1:0] GPO_CODE = SEL_W'(SRC_N - 1);

   initial begin
      if ((1 << SEL_W) != SRC_N) $error("selector width does not match source count");
   end

   logic picked;

   always_comb begin
      if (!en)                  picked = 1'b0;
      else if (sel == GPO_CODE) picked = gpo_bit;
      else                      picked = probes[sel];
   end

   generate
      if (REG_OUT) begin : g_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pin <= 1'b0;
            else        pin <= picked;
         end
      end else begin : g_direct
         assign pin = picked;

         p_gpo_route_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (en && sel == GPO_CODE) |-> (pin == gpo_bit));

         p_off_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !en |-> !pin);
      end
   endgenerate
endmodule

// File: rtl/dbg_obs_mux.sv
module dbg_obs_mux
   import dbg_obs_mux_pkg::*;
#(
   parameter int          NUM_PINS  = 8,
   parameter int          SRC_N     = 16,
   parameter bit          REG_OUT   = 1'b0,
   parameter logic [3:0]  VER_MAJOR = 4'd1,
   parameter logic [3:0]  VER_MINOR = 4'd0,
   parameter logic [31:0] ID_WORD0  = 32'h4442_4D58,
   parameter logic [31:0] ID_WORD1  = 32'h0000_A3C5
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      psel,
   input  logic                      penable,
   input  logic                      pwrite,
   input  logic [11:0]               paddr,
   input  logic [31:0]               pwdata,
   output logic [31:0]               prdata,
   input  logic [NUM_PINS*SRC_N-1:0] probe_in,
   output logic [NUM_PINS-1:0]       dbg_out
);
   localparam int SEL_W = $clog2(SRC_N);

   initial begin
      if (SRC_N < 2) $error("at least two sources per pin are needed");
   end

   logic                      en;
   logic [NUM_PINS*SEL_W-1:0] sel_all;
   logic [NUM_PINS-1:0]       gpo;

   dbg_obs_mux_regs #(
      .NUM_PINS (NUM_PINS),
      .SEL_W    (SEL_W),
      .VER_MAJOR(VER_MAJOR),
      .VER_MINOR(VER_MINOR),
      .ID_WORD0 (ID_WORD0),
      .ID_WORD1 (ID_WORD1)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .psel   (psel),
      .penable(penable),
      .pwrite (pwrite),
      .paddr  (paddr),
      .pwdata (pwdata),
      .prdata (prdata),
      .pin_val(dbg_out),
      .en     (en),
      .sel_all(sel_all),
      .gpo    (gpo)
   );

   generate
      for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
         dbg_obs_mux_pin #(
            .SRC_N  (SRC_N),
            .SEL_W  (SEL_W),
            .REG_OUT(REG_OUT)
         ) u_pin (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (en),
            .sel    (sel_all[n*SEL_W +: SEL_W]),
            .gpo_bit(gpo[n]),
            .probes (probe_in[n*SRC_N +: SRC_N]),
            .pin    (dbg_out[n])
         );
      end
   endgenerate

   p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (dbg_out == '0));
endmodule

// File: tb/dbg_obs_mux_bench.sv
`timescale 1ns/1ps
module dbg_obs_mux_bench;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [11:0]  paddr = '0;
   logic [31:0]  pwdata = '0;
   logic [31:0]  prdata;
   logic [127:0] probe_in = '0;
   logic [7:0]   dbg_out;

   int  n_total = 0;
   int  n_fail  = 0;
   bit  done    = 1'b0;

   bit        m_en;
   bit [31:0] m_sel;
   bit [7:0]  m_gpo;

   always #5 clk = ~clk;

   dbg_obs_mux #(
      .VER_MAJOR(4'd1), .VER_MINOR(4'd0),
      .ID_WORD0(32'h4442_4D58), .ID_WORD1(32'h0000_A3C5)
   ) u_dbg_obs_mux (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
      .probe_in(probe_in), .dbg_out(dbg_out)
   );

   function automatic bit [7:0] model_pins(bit en, bit [31:0] sel, bit [7:0] g, bit [127:0] pr);
      bit [7:0] r = '0;
      for (int n = 0; n < 8; n++) begin
         bit [3:0] s = sel[n*4 +: 4];
         if (!en)          r[n] = 1'b0;
         else if (s == 15) r[n] = g[n];
         else              r[n] = pr[n*16 + s];
      end
      return r;
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_total++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
   endtask

   task automatic apb_write(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
      @(negedge clk);
      penable = 1'b1;
      @(negedge clk);
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
      if (a == 12'h000) m_en = d[0];
      if (a == 12'h004) m_sel = d;
      if (a == 12'h014) m_gpo = m_gpo | d[7:0];
      if (a == 12'h018) m_gpo = m_gpo & ~d[7:0];
   endtask

   task automatic apb_read(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
      @(negedge clk);
      penable = 1'b1;
      #1 d = prdata;
      @(negedge clk);
      psel = 1'b0; penable = 1'b0;
   endtask

   task automatic expect_read(input logic [11:0] a, input logic [31:0] e, input string req);
      logic [31:0] d;
      apb_read(a, d);
      check(d === e, req, d, e);
   endtask

   task automatic check_pins(input string req);
      bit [7:0] e;
      #1 e = model_pins(m_en, m_sel, m_gpo, probe_in);
      check(dbg_out === e, req, {24'b0, dbg_out}, {24'b0, e});
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_total++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] saved;
      void'($urandom(32'h1D5E_0042));
      m_en = 0; m_sel = 0; m_gpo = 0;
      probe_in = {4{$urandom()}};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check_pins("R1 pins after reset");
      expect_read(12'h000, 32'h0, "R1 ctrl reset");
      expect_read(12'h004, 32'h0, "R1 mux reset");
      expect_read(12'h01C, 32'h0, "R1 gpo reset");

      // R9 version and identification
      expect_read(12'h3F4, 32'h0000_0010, "R9 version");
      expect_read(12'h3F8, 32'h4442_4D58, "R9 id0");
      expect_read(12'h3FC, 32'h0000_A3C5, "R9 id1");

      // R2 disabled gating with GPO and mux set
      apb_write(12'h004, 32'hFFFF_FFFF);
      apb_write(12'h014, 32'h0000_00FF);
      check_pins("R2 disabled pins");
      check(dbg_out === 8'h00, "R2 disabled pins zero", {24'b0, dbg_out}, 32'h0);
      apb_write(12'h000, 32'hFFFF_FFFF);
      expect_read(12'h000, 32'h1, "R2 ctrl only bit0");
      check_pins("R4 all pins on gpo");

      // R6 clear and R5 set with 0s elsewhere
      apb_write(12'h018, 32'h0000_00A5);
      expect_read(12'h01C, 32'h5A, "R6 clear ones");
      apb_write(12'h014, 32'h0000_0001);
      expect_read(12'h014, 32'h5B, "R5 set keeps others");
      expect_read(12'h018, 32'h0, "R10 clear reads zero");

      // R7 save / restore
      apb_read(12'h014, saved);
      apb_write(12'h018, 32'hFF);
      expect_read(12'h01C, 32'h0, "R7 fully cleared");
      apb_write(12'h014, saved);
      expect_read(12'h01C, {24'b0, m_gpo}, "R7 restored");
      check(m_gpo == 8'h5B, "R7 model restore", {24'b0, m_gpo}, 32'h5B);

      // R10 writes to read-only and unmapped
      apb_write(12'h010, 32'hFFFF_FFFF);
      apb_write(12'h01C, 32'h0);
      apb_write(12'h3F4, 32'h0);
      apb_write(12'h3F8, 32'h0);
      apb_write(12'h3FC, 32'h0);
      apb_write(12'h100, 32'h0);
      expect_read(12'h01C, 32'h5B, "R10 gpo untouched");
      expect_read(12'h004, 32'hFFFF_FFFF, "R10 mux untouched");
      expect_read(12'h000, 32'h1, "R10 ctrl untouched");
      expect_read(12'h3F8, 32'h4442_4D58, "R10 id0 fixed");
      expect_read(12'h100, 32'h0, "R10 unmapped reads zero");

      // R4 coincidence: gpo writes while probes toggle on code-15 pins
      for (int i = 0; i < 16; i++) begin
         probe_in = {4{$urandom()}};
         apb_write((i % 2) ? 12'h018 : 12'h014, $urandom() & 32'hFF);
         probe_in = ~probe_in;
         check_pins("R4 gpo code ignores probes");
      end

      // R3 directed corner selectors 0 and 14
      apb_write(12'h004, 32'h0000_0000);
      probe_in = '0;
      for (int n = 0; n < 8; n++) probe_in[n*16] = n[0];
      check_pins("R3 selector 0");
      apb_write(12'h004, 32'hEEEE_EEEE);
      probe_in = '0;
      for (int n = 0; n < 8; n++) probe_in[n*16 + 14] = 1'b1;
      check_pins("R3 selector 14");
      check(dbg_out === 8'hFF, "R3 selector 14 ones", {24'b0, dbg_out}, 32'hFF);

      // R3 / R8 random mixes, including pin value reads
      for (int i = 0; i < 40; i++) begin
         logic [31:0] d;
         apb_write(12'h004, $urandom());
         if (i % 5 == 0) apb_write(12'h000, {31'b0, 1'(i % 3 != 0)});
         probe_in = {4{$urandom()}};
         check_pins("R3 random selectors");
         apb_read(12'h010, d);
         check(d === {24'b0, model_pins(m_en, m_sel, m_gpo, probe_in)}, "R8 pin value register",
               d, {24'b0, model_pins(m_en, m_sel, m_gpo, probe_in)});
      end

      // R2 disable again
      apb_write(12'h000, 32'h0);
      probe_in = '1;
      check_pins("R2 disabled after use");

      done = 1'b1;
      summary();
      $finish;
   end
endmodule